// File: doc/BRIEF.md
# Packet Buffer Page Manager

This block keeps track of a shared packet buffer cut into fixed-size pages. Each page is named by a packet number. Software sends commands to the block: allocate a page, release a page, queue a packet for sending, take the top entry off the receive queue and free its page, clear the transmit queues, or reset the whole manager. A free-page bitmap picks the lowest-numbered free page in the same cycle as the request.

Three queues of packet numbers sit beside the bitmap: transmit, transmit-completion and receive. The MAC takes packets from the head of the transmit queue, pushes the numbers of received packets, and reports when each transmission ends. If auto-release is on, a packet that was sent successfully skips the completion queue and its page goes straight back to the pool.

Software sees the head of each queue with an empty flag packed above the packet number. It also sees the allocation result and the interrupt sources. Total and free memory are reported as page counts. One page holds 256 times a multiplier bytes.

Top module: `pkt_mem_mgr`

## Requirements
- R1: After reset every page is free and all three queues are empty. `alloc_fail` is 1, `alloc_int` is 0 and `tx_empty_int` is 1.
- R2: Command ALLOC (code 1), when a page is free, makes three changes by the next cycle. `alloc_pn` becomes the lowest free page number, `alloc_fail` becomes 0 and `alloc_int` becomes 1. The free count drops by one.
- R3: ALLOC when no page is free sets `alloc_fail` to 1 and `alloc_int` to 0, and leaves the free count unchanged. Once a page has been freed, a retried ALLOC succeeds.
- R4: Command RELEASE (code 4) returns page `cmd_pn` to the pool. A later ALLOC can hand that page out again.
- R5: Command TX_ENQ (code 5) appends `cmd_pn` to the transmit queue, which the MAC reads in first-in first-out order through `tx_head_pn` and `tx_pop`. `tx_empty_int` is 1 exactly when the transmit queue is empty.
- R6: A completion report (`tx_done_valid`) with `tx_done_ok`=1 while `auto_release`=1 frees page `tx_done_pn` and adds nothing to the completion queue. Any other report pushes `tx_done_pn` onto the completion queue. `tx_int` is 1 while the completion queue holds entries, and command DONE_POP (code 7) removes its head.
- R7: `rx_push` appends `rx_pn` to the receive queue, and `rx_int` equals the inverse of the receive queue's empty flag. Command RX_POP_REL (code 3) removes the receive head and frees its page.
- R8: `rx_head_word` and `done_head_word` carry the empty flag in bit PN_W (1 = empty) and the head packet number in bits PN_W-1:0. The number bits read 0 when the queue is empty.
- R9: Command TXQ_RESET (code 6) empties the transmit and completion queues and frees no page.
- R10: Command MMU_RESET (code 2) frees every page and empties all three queues. It also sets `alloc_fail` to 1 and clears `alloc_int`.
- R11: `mem_size` and `mem_free` report page counts, where one page holds 256×MULT bytes. A count of 256 is encoded as FFh. `mem_mult` outputs MULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_pn | input | PN_W | Packet number operand |
| auto_release | input | 1 | Free successfully sent pages without queuing them |
| alloc_fail | output | 1 | Last allocation failed (set on reset) |
| alloc_int | output | 1 | Allocation succeeded interrupt source |
| alloc_pn | output | PN_W | Page granted by last successful ALLOC |
| tx_head_valid | output | 1 | Transmit queue not empty |
| tx_head_pn | output | PN_W | Transmit queue head |
| tx_pop | input | 1 | MAC takes transmit head |
| tx_done_valid | input | 1 | MAC reports end of a transmission |
| tx_done_ok | input | 1 | Transmission succeeded |
| tx_done_pn | input | PN_W | Packet number of the finished transmission |
| rx_push | input | 1 | MAC pushes a received packet number |
| rx_pn | input | PN_W | Received packet number |
| rx_head_word | output | PN_W+1 | Receive head with empty flag on top |
| done_head_word | output | PN_W+1 | Completion head with empty flag on top |
| rx_int | output | 1 | Receive queue not empty |
| tx_int | output | 1 | Completion queue not empty |
| tx_empty_int | output | 1 | Transmit queue empty |
| mem_size | output | 8 | Total pages (256 shown as FFh) |
| mem_free | output | 8 | Free pages (256 shown as FFh) |
| mem_mult | output | 8 | Page size multiplier |

## Verification
The bench builds one instance with 8 pages and MULT=2. With so few pages it can exhaust the pool, fail an allocation and retry it after a release. It can also drive all three queues through their wrap and clear paths within a few dozen commands. A second instance with 256 pages checks that a full page count is reported as FFh.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_ALLOC      = 3'd1,
    OP_MMU_RESET  = 3'd2,
    OP_RX_POP_REL = 3'd3,
    OP_RELEASE    = 3'd4,
    OP_TX_ENQ     = 3'd5,
    OP_TXQ_RESET  = 3'd6,
    OP_DONE_POP   = 3'd7
  } pmm_op_e;

  // Page count to reported code: 256 pages read back as FFh (R11)
  function automatic logic [7:0] units_code(input logic [15:0] pages);
    return (pages >= 16'd256) ? 8'hFF : pages[7:0];
  endfunction
endpackage

// File: rtl/pmm_pn_fifo.sv
module pmm_pn_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          do_pop, do_push;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && ((cnt != CW'(DEPTH)) || do_pop);
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
      if (do_push) wr_ptr <= wrap_inc(wr_ptr);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R5
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty); // R9
endmodule

// File: rtl/pmm_page_pool.sv
module pmm_page_pool #(
  parameter int PAGES = 8,
  parameter int PW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          free_all,
  input  logic          take,
  input  logic          rel_a,
  input  logic [PW-1:0] rel_a_pn,
  input  logic          rel_b,
  input  logic [PW-1:0] rel_b_pn,
  output logic          any_free,
  output logic [PW-1:0] low_pn,
  output logic [CW-1:0] free_cnt
);
  logic [PAGES-1:0] free_map, map_nxt;
  logic             take_ok;

  assign any_free = |free_map;
  assign take_ok  = take && any_free;

  // Lowest free page, found in one cycle
  always_comb begin
    low_pn = '0;
    for (int i = PAGES - 1; i >= 0; i--)
      if (free_map[i]) low_pn = PW'(i);
  end

  always_comb begin
    free_cnt = '0;
    for (int i = 0; i < PAGES; i++) free_cnt = free_cnt + CW'(free_map[i]);
  end

  always_comb begin
    map_nxt = free_map;
    if (take_ok) map_nxt[low_pn] = 1'b0;
    if (rel_a)   map_nxt[rel_a_pn] = 1'b1;
    if (rel_b)   map_nxt[rel_b_pn] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || free_all) free_map <= '1;
    else                    free_map <= map_nxt;
  end

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && !free_all && !(rel_a && rel_a_pn == low_pn) && !(rel_b && rel_b_pn == low_pn)
    |=> !free_map[$past(low_pn)]); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && !free_all && !rel_a && !rel_b |=> free_cnt == $past(free_cnt) - 1'b1); // R2
  AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    take && !any_free && !free_all && !rel_a && !rel_b |=> free_cnt == '0); // R3
endmodule

// File: rtl/pkt_mem_mgr.sv
module pkt_mem_mgr
  import pmm_pkg::*;
#(
  parameter int NUM_PAGES = 64,
  parameter int MULT      = 1,
  localparam int PN_W     = $clog2(NUM_PAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [PN_W-1:0] cmd_pn,
  input  logic            auto_release,
  output logic            alloc_fail,
  output logic            alloc_int,
  output logic [PN_W-1:0] alloc_pn,
  output logic            tx_head_valid,
  output logic [PN_W-1:0] tx_head_pn,
  input  logic            tx_pop,
  input  logic            tx_done_valid,
  input  logic            tx_done_ok,
  input  logic [PN_W-1:0] tx_done_pn,
  input  logic            rx_push,
  input  logic [PN_W-1:0] rx_pn,
  output logic [PN_W:0]   rx_head_word,
  output logic [PN_W:0]   done_head_word,
  output logic            rx_int,
  output logic            tx_int,
  output logic            tx_empty_int,
  output logic [7:0]      mem_size,
  output logic [7:0]      mem_free,
  output logic [7:0]      mem_mult
);
  localparam int CW = $clog2(NUM_PAGES + 1);

  pmm_op_e op;
  assign op = pmm_op_e'(cmd_op);

  // Named internal events
  logic ev_alloc, ev_mmu_rst, ev_rx_pop_rel, ev_release, ev_tx_enq, ev_txq_rst, ev_done_pop;
  logic ev_auto_rel, ev_done_push, ev_rx_free;
  assign ev_alloc      = cmd_valid && (op == OP_ALLOC);
  assign ev_mmu_rst    = cmd_valid && (op == OP_MMU_RESET);
  assign ev_rx_pop_rel = cmd_valid && (op == OP_RX_POP_REL);
  assign ev_release    = cmd_valid && (op == OP_RELEASE);
  assign ev_tx_enq     = cmd_valid && (op == OP_TX_ENQ);
  assign ev_txq_rst    = cmd_valid && (op == OP_TXQ_RESET);
  assign ev_done_pop   = cmd_valid && (op == OP_DONE_POP);
  assign ev_auto_rel   = tx_done_valid && tx_done_ok && auto_release;
  assign ev_done_push  = tx_done_valid && !ev_auto_rel;

  logic            tx_empty, rx_empty, done_empty, any_free;
  logic [PN_W-1:0] rx_head_pn, done_head_pn, low_pn;
  logic [CW-1:0]   free_cnt;

  assign ev_rx_free = ev_rx_pop_rel && !rx_empty;

  pmm_page_pool #(.PAGES(NUM_PAGES), .PW(PN_W), .CW(CW)) u_pool (
    .clk, .rst_n,
    .free_all (ev_mmu_rst),
    .take     (ev_alloc),
    .rel_a    (ev_release || ev_rx_free),
    .rel_a_pn (ev_release ? cmd_pn : rx_head_pn),
    .rel_b    (ev_auto_rel),
    .rel_b_pn (tx_done_pn),
    .any_free (any_free),
    .low_pn   (low_pn),
    .free_cnt (free_cnt)
  );

  pmm_pn_fifo #(.DEPTH(NUM_PAGES), .W(PN_W)) u_txq (
    .clk, .rst_n, .clr(ev_mmu_rst || ev_txq_rst),
    .push(ev_tx_enq), .din(cmd_pn), .pop(tx_pop),
    .head(tx_head_pn), .empty(tx_empty)
  );

  pmm_pn_fifo #(.DEPTH(NUM_PAGES), .W(PN_W)) u_doneq (
    .clk, .rst_n, .clr(ev_mmu_rst || ev_txq_rst),
    .push(ev_done_push), .din(tx_done_pn), .pop(ev_done_pop),
    .head(done_head_pn), .empty(done_empty)
  );

  pmm_pn_fifo #(.DEPTH(NUM_PAGES), .W(PN_W)) u_rxq (
    .clk, .rst_n, .clr(ev_mmu_rst),
    .push(rx_push), .din(rx_pn), .pop(ev_rx_pop_rel),
    .head(rx_head_pn), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || ev_mmu_rst) begin
      alloc_fail <= 1'b1;
      alloc_int  <= 1'b0;
      alloc_pn   <= '0;
    end else if (ev_alloc) begin
      alloc_fail <= !any_free;
      alloc_int  <= any_free;
      if (any_free) alloc_pn <= low_pn;
    end
  end

  assign tx_head_valid  = !tx_empty;
  assign tx_empty_int   = tx_empty;
  assign rx_int         = !rx_empty;
  assign tx_int         = !done_empty;
  assign rx_head_word   = {rx_empty, rx_head_pn};
  assign done_head_word = {done_empty, done_head_pn};
  assign mem_size       = units_code(16'(NUM_PAGES));
  assign mem_free       = units_code(16'(free_cnt));
  assign mem_mult       = 8'(MULT);

  AST_MMU_RST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mmu_rst |=> alloc_fail && !alloc_int && mem_free == mem_size && !rx_int); // R10
  AST_FAIL_NO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fail |-> !alloc_int); // R3
  AST_RX_PUSH_INT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !ev_mmu_rst |=> rx_int); // R7
  AST_AUTO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_auto_rel && done_empty |=> done_head_word[PN_W]); // R6
  AST_TXQ_RST_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txq_rst && !tx_done_valid |=> mem_free == $past(mem_free)); // R9
endmodule

// File: tb/pkt_mem_mgr_bench.sv
module pkt_mem_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          cmd_valid = 0, auto_release = 0, tx_pop = 0;
  logic          tx_done_valid = 0, tx_done_ok = 0, rx_push = 0;
  logic [2:0]    cmd_op = 0;
  logic [PW-1:0] cmd_pn = 0, tx_done_pn = 0, rx_pn = 0;
  logic          alloc_fail, alloc_int, tx_head_valid, rx_int, tx_int, tx_empty_int;
  logic [PW-1:0] alloc_pn, tx_head_pn;
  logic [PW:0]   rx_head_word, done_head_word;
  logic [7:0]    mem_size, mem_free, mem_mult;

  pkt_mem_mgr #(.NUM_PAGES(NP), .MULT(2)) u_pkt_mem_mgr (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_pn, .auto_release,
    .alloc_fail, .alloc_int, .alloc_pn, .tx_head_valid, .tx_head_pn, .tx_pop,
    .tx_done_valid, .tx_done_ok, .tx_done_pn, .rx_push, .rx_pn,
    .rx_head_word, .done_head_word, .rx_int, .tx_int, .tx_empty_int,
    .mem_size, .mem_free, .mem_mult
  );

  logic       b_fail, b_int, b_txv, b_rxi, b_txi, b_txe;
  logic [7:0] b_apn, b_txpn, b_size, b_free, b_mult;
  logic [8:0] b_rxw, b_dnw;
  pkt_mem_mgr #(.NUM_PAGES(256), .MULT(1)) u_big (
    .clk, .rst_n, .cmd_valid(1'b0), .cmd_op(3'd0), .cmd_pn(8'd0), .auto_release(1'b0),
    .alloc_fail(b_fail), .alloc_int(b_int), .alloc_pn(b_apn), .tx_head_valid(b_txv),
    .tx_head_pn(b_txpn), .tx_pop(1'b0), .tx_done_valid(1'b0), .tx_done_ok(1'b0),
    .tx_done_pn(8'd0), .rx_push(1'b0), .rx_pn(8'd0), .rx_head_word(b_rxw),
    .done_head_word(b_dnw), .rx_int(b_rxi), .tx_int(b_txi), .tx_empty_int(b_txe),
    .mem_size(b_size), .mem_free(b_free), .mem_mult(b_mult)
  );

  // {op[2:0], arg[2:0], exp_fail, exp_pn[2:0], exp_free[7:0]}
  localparam logic [17:0] VEC [8] = '{
    {3'd1, 3'd0, 1'b0, 3'd0, 8'd7},
    {3'd1, 3'd0, 1'b0, 3'd1, 8'd6},
    {3'd1, 3'd0, 1'b0, 3'd2, 8'd5},
    {3'd4, 3'd1, 1'b0, 3'd2, 8'd6},
    {3'd1, 3'd0, 1'b0, 3'd1, 8'd5},
    {3'd4, 3'd0, 1'b0, 3'd1, 8'd6},
    {3'd4, 3'd2, 1'b0, 3'd1, 8'd7},
    {3'd1, 3'd0, 1'b0, 3'd0, 8'd6}
  };

  int total = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [PW-1:0] pn);
    cmd_valid = 1; cmd_op = op; cmd_pn = pn;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
  endtask

  task automatic mac_pop();
    tx_pop = 1; @(negedge clk); tx_pop = 0;
  endtask

  task automatic mac_done(input logic ok, input logic [PW-1:0] pn);
    tx_done_valid = 1; tx_done_ok = ok; tx_done_pn = pn;
    @(negedge clk);
    tx_done_valid = 0;
  endtask

  task automatic mac_rx(input logic [PW-1:0] pn);
    rx_push = 1; rx_pn = pn; @(negedge clk); rx_push = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 alloc_fail", alloc_fail, 1);
    chk("R1 alloc_int", alloc_int, 0);
    chk("R1 mem_free", mem_free, NP);
    chk("R1 tx_empty_int", tx_empty_int, 1);
    chk("R8 rx_head_word empty", rx_head_word, 4'b1000);
    chk("R8 done_head_word empty", done_head_word, 4'b1000);
    chk("R1 rx_int/tx_int", {rx_int, tx_int}, 0);
    // R11 reporting
    chk("R11 mem_size", mem_size, NP);
    chk("R11 mem_mult", mem_mult, 2);
    chk("R11 256 pages size FFh", b_size, 8'hFF);
    chk("R11 256 pages free FFh", b_free, 8'hFF);

    // Table walk: R2 / R4
    for (int i = 0; i < 8; i++) begin
      cmd(VEC[i][17:15], VEC[i][14:12]);
      chk("R2 R4 table alloc_fail", alloc_fail, VEC[i][11]);
      chk("R2 R4 table alloc_pn", alloc_pn, VEC[i][10:8]);
      chk("R2 R4 table mem_free", mem_free, VEC[i][7:0]);
    end
    chk("R2 alloc_int after grant", alloc_int, 1);

    // R5 transmit queue order
    cmd(3'd5, 3'd0);
    cmd(3'd5, 3'd1);
    chk("R5 tx_head_valid", tx_head_valid, 1);
    chk("R5 tx head first", tx_head_pn, 0);
    chk("R5 tx_empty_int low", tx_empty_int, 0);
    mac_pop();
    chk("R5 tx head second", tx_head_pn, 1);

    // R6 auto-release bypass
    auto_release = 1;
    mac_done(1, 3'd0);
    chk("R6 auto release frees", mem_free, 7);
    chk("R6 completion bypassed", done_head_word, 4'b1000);
    chk("R6 tx_int low", tx_int, 0);
    mac_pop();
    chk("R5 tx_empty_int after drain", tx_empty_int, 1);
    chk("R5 tx_head_valid after drain", tx_head_valid, 0);
    mac_done(0, 3'd1);
    chk("R6 R8 failed send queued", done_head_word, 4'b0001);
    chk("R6 tx_int high", tx_int, 1);
    chk("R6 failed send keeps page", mem_free, 7);
    cmd(3'd7, 3'd0);
    chk("R6 done pop", done_head_word, 4'b1000);
    chk("R6 tx_int cleared", tx_int, 0);
    cmd(3'd4, 3'd1);
    chk("R4 release", mem_free, 8);

    // R3 exhaustion
    for (int i = 0; i < NP; i++) begin
      cmd(3'd1, 3'd0);
      chk("R2 sequential grant", alloc_pn, i);
    end
    chk("R3 pool empty", mem_free, 0);
    cmd(3'd1, 3'd0);
    chk("R3 fail set", alloc_fail, 1);
    chk("R3 no alloc_int", alloc_int, 0);
    chk("R3 free unchanged", mem_free, 0);

    // R7 receive queue
    mac_rx(3'd3);
    mac_rx(3'd5);
    chk("R7 rx_int", rx_int, 1);
    chk("R7 R8 rx head", rx_head_word, 4'b0011);
    cmd(3'd3, 3'd0);
    chk("R7 pop to next", rx_head_word, 4'b0101);
    chk("R7 page freed", mem_free, 1);
    cmd(3'd1, 3'd0);
    chk("R3 retry pn", alloc_pn, 3);
    chk("R3 retry fail clear", alloc_fail, 0);
    chk("R3 retry int", alloc_int, 1);
    cmd(3'd3, 3'd0);
    chk("R7 rx empty", rx_head_word, 4'b1000);
    chk("R7 rx_int low", rx_int, 0);
    chk("R7 second page freed", mem_free, 1);

    // R9 transmit queue reset
    cmd(3'd5, 3'd2);
    mac_done(0, 3'd4);
    chk("R9 pre done queued", done_head_word, 4'b0100);
    cmd(3'd6, 3'd0);
    chk("R9 tx queue empty", tx_empty_int, 1);
    chk("R9 done queue empty", done_head_word, 4'b1000);
    chk("R9 no memory freed", mem_free, 1);

    // R10 full reset
    mac_rx(3'd6);
    cmd(3'd2, 3'd0);
    chk("R10 all free", mem_free, NP);
    chk("R10 fail set", alloc_fail, 1);
    chk("R10 int clear", alloc_int, 0);
    chk("R10 rx cleared", rx_head_word, 4'b1000);

    finished = 1;
    summary();
    $finish;
  end
endmodule